// File: doc/BRIEF.md
# PS/2 Keyboard Scan-Code Receiver

This block listens to the clock and data lines of a PS/2 keyboard and turns each serial frame into one 8-bit parallel scan code. It works on a fast system clock (nominally 48 MHz). The keyboard clock is brought into that domain through a synchronizer and then cleaned by a glitch filter. Each data bit is sampled on the filtered falling edge of the keyboard clock.

A frame has eleven bits, sent in this order: a start bit of 0, eight data bits with the least significant bit first, an odd parity bit and a stop bit of 1. When a frame is good, its byte appears on `scan_code` and `code_ready` goes high. The flag is sticky: it drops only when the consumer pulses `rd_strobe`, so the consumer takes each code exactly once. The block does not interpret the bytes. A press, a release prefix (F0), an extended prefix (E0) and every auto-repeat of a held key each arrive as a separate code.

Top module: `ps2_scan_receiver`

## Requirements
- R1: While `rst_n` is low at a clock edge, `code_ready` and `scan_code` become 0 and the partly assembled frame and its bit count are discarded. A frame sent after reset is decoded correctly even if reset struck in the middle of an earlier frame.
- R2: A frame is start=0, then data bits 0 to 7 (LSB first), then parity, then stop=1, each sampled on a falling keyboard-clock edge. When the frame is good, `scan_code` takes the data byte and `code_ready` goes to 1.
- R3: A frame whose parity bit does not make the nine bits (data plus parity) contain an odd number of ones leaves `code_ready` and `scan_code` unchanged.
- R4: A frame whose start bit is 1 leaves `code_ready` and `scan_code` unchanged.
- R5: A frame whose stop bit is 0 leaves `code_ready` and `scan_code` unchanged.
- R6: A one-cycle pulse on `rd_strobe` clears `code_ready` on the next edge and leaves `scan_code` holding its value.
- R7: If a good frame completes while `code_ready` is still 1, `scan_code` takes the new byte and `code_ready` stays 1.
- R8: Prefix bytes (F0 for release, E0 for extended) and repeated identical make codes are each delivered as their own code, and each sets `code_ready` again.
- R9: A low pulse on the keyboard clock that is shorter than `FILT_LEN` system clocks is not taken as an edge, so the frame being received is unaffected.
- R10: With no good frame and no `rd_strobe`, `code_ready` and `scan_code` keep their values.
- R11: If `rd_strobe` is high in the same cycle that a good frame is captured, the capture wins and `code_ready` is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (nominally 48 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| ps2_clk_in | input | 1 | Keyboard clock line, asynchronous |
| ps2_dat_in | input | 1 | Keyboard data line, asynchronous |
| rd_strobe | input | 1 | Consumer read pulse; clears the ready flag |
| scan_code | output | 8 | Last good scan code |
| code_ready | output | 1 | High when an unread code is waiting |

## Verification
The bench builds the block with `FILT_LEN` = 4 and two synchronizer stages. The keyboard clock then runs at 20 system clocks per half period, which keeps every frame short. A 2-cycle glitch is well below the filter length, so the glitch-rejection case can be reached. The latency from the final falling edge to the rise of the ready flag is also fixed and easy to count, so the bench can place a read strobe in exactly the capture cycle to test the collision rule.

// File: rtl/ps2rx_pkg.sv
// Package: shared constants for the PS/2 scan-code receiver.
// Assumes an 8-bit payload framed by start, odd parity and stop bits.
package ps2rx_pkg;
    localparam int unsigned CODE_W     = 8;
    localparam int unsigned FRAME_BITS = CODE_W + 3;
    localparam logic        START_VAL  = 1'b0;
    localparam logic        STOP_VAL   = 1'b1;

    // Captured frame fields after assembly.
    typedef struct packed {
        logic              stop;
        logic              parity;
        logic [CODE_W-1:0] data;
        logic              start;
    } ps2_frame_t;
endpackage

// File: rtl/ps2_sync_chain.sv
// Module: ps2_sync_chain
// Moves one asynchronous level into the clk domain through STAGES flops.
// Assumes STAGES >= 2; the reset value is the idle level of the line.
module ps2_sync_chain #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the synchronizer flops.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign d_sync = chain_q[STAGES-1];
endmodule

// File: rtl/ps2_clk_filter.sv
// Module: ps2_clk_filter
// Accepts a new keyboard-clock level only after FILT_LEN consecutive
// samples disagree with the current filtered level; emits a one-cycle
// pulse when the filtered level goes from high to low.
// Assumes a synchronized input and FILT_LEN >= 2.
module ps2_clk_filter #(
    parameter int unsigned FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clk_sync,
    output logic fall_pulse
);
    localparam int unsigned CW = $clog2(FILT_LEN);

    logic          filt_q;
    logic [CW-1:0] run_q;

    // Count disagreeing samples and flip the filtered level once enough agree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q     <= 1'b1;
            run_q      <= '0;
            fall_pulse <= 1'b0;
        end else begin
            fall_pulse <= 1'b0;
            if (clk_sync == filt_q) begin
                run_q <= '0;
            end else if (run_q == CW'(FILT_LEN - 1)) begin
                filt_q     <= clk_sync;
                run_q      <= '0;
                fall_pulse <= filt_q;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    // A falling pulse must coincide with a low filtered level that was high before.
    assert_fall_is_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fall_pulse |-> (!filt_q && $past(filt_q)));
endmodule

// File: rtl/ps2_frame_rx.sv
// Module: ps2_frame_rx
// Collects FRAME_BITS samples, one per falling edge, and checks start,
// odd parity and stop. A good frame yields a one-cycle valid pulse with
// the byte. Assumes bits arrive start first, data LSB first.
module ps2_frame_rx
    import ps2rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              bit_val,
    output logic              frame_ok,
    output logic [CODE_W-1:0] frame_byte
);
    localparam int unsigned CNT_W = $clog2(FRAME_BITS + 1);

    logic [FRAME_BITS-1:0] shift_q;
    logic [CNT_W-1:0]      count_q;
    logic [FRAME_BITS-1:0] shift_nxt;
    ps2_frame_t            view;
    logic                  last_bit;
    logic                  good;

    // Form the frame as it would look with the present bit shifted in.
    always_comb begin
        shift_nxt = {bit_val, shift_q[FRAME_BITS-1:1]};
        view      = ps2_frame_t'(shift_nxt);
        last_bit  = (count_q == CNT_W'(FRAME_BITS - 1));
        good      = (view.start == START_VAL) && (view.stop == STOP_VAL)
                    && (^{view.data, view.parity} == 1'b1);
    end

    // Shift bits in, wrap the count at frame end and report good frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q    <= '0;
            count_q    <= '0;
            frame_ok   <= 1'b0;
            frame_byte <= '0;
        end else begin
            frame_ok <= 1'b0;
            if (bit_tick) begin
                shift_q <= shift_nxt;
                if (last_bit) begin
                    count_q <= '0;
                    if (good) begin
                        frame_ok   <= 1'b1;
                        frame_byte <= view.data;
                    end
                end else begin
                    count_q <= count_q + 1'b1;
                end
            end
        end
    end

    // The bit position never passes the last frame slot.
    assert_bitcnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_W'(FRAME_BITS - 1));
    // A valid pulse only follows a sampled bit.
    assert_valid_after_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> $past(bit_tick));
endmodule

// File: rtl/ps2_code_hold.sv
// Module: ps2_code_hold
// Holds the last good code and a sticky ready flag cleared by a read.
// Assumes capture and read may coincide; capture takes priority.
module ps2_code_hold
    import ps2rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [CODE_W-1:0] cap_byte,
    input  logic              rd_strobe,
    output logic [CODE_W-1:0] code_q,
    output logic              ready_q
);
    // Latch new codes and manage the ready handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q  <= '0;
            ready_q <= 1'b0;
        end else if (cap_en) begin
            code_q  <= cap_byte;
            ready_q <= 1'b1;
        end else if (rd_strobe) begin
            ready_q <= 1'b0;
        end
    end

    assert_capture_sets_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> (ready_q && code_q == $past(cap_byte)));
    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !cap_en) |=> (!ready_q && $stable(code_q)));
    assert_hold_steady_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap_en && !rd_strobe) |=> ($stable(ready_q) && $stable(code_q)));
endmodule

// File: rtl/ps2_scan_receiver.sv
// Module: ps2_scan_receiver (top)
// Receives PS/2 keyboard frames and presents each good byte with a
// sticky ready flag. Clock line: synchronized then filtered; data line:
// synchronized and sampled on the filtered falling edge.
// Assumes the system clock is far faster than the keyboard clock.
module ps2_scan_receiver #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_in,
    input  logic       ps2_dat_in,
    input  logic       rd_strobe,
    output logic [7:0] scan_code,
    output logic       code_ready
);
    import ps2rx_pkg::*;

    logic              kclk_s;
    logic              kdat_s;
    logic              fall_tick;
    logic              frm_ok;
    logic [CODE_W-1:0] frm_byte;

    ps2_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .d_async(ps2_clk_in), .d_sync(kclk_s));

    ps2_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_dat (
        .clk(clk), .rst_n(rst_n), .d_async(ps2_dat_in), .d_sync(kdat_s));

    ps2_clk_filter #(.FILT_LEN(FILT_LEN)) u_filter (
        .clk(clk), .rst_n(rst_n), .clk_sync(kclk_s), .fall_pulse(fall_tick));

    ps2_frame_rx u_frame (
        .clk(clk), .rst_n(rst_n), .bit_tick(fall_tick), .bit_val(kdat_s),
        .frame_ok(frm_ok), .frame_byte(frm_byte));

    ps2_code_hold u_hold (
        .clk(clk), .rst_n(rst_n), .cap_en(frm_ok), .cap_byte(frm_byte),
        .rd_strobe(rd_strobe), .code_q(scan_code), .ready_q(code_ready));

    // Capture wins over a simultaneous read.
    assert_collide_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_ok && rd_strobe) |=> code_ready);
endmodule

// File: tb/tb_ps2_scan_receiver.sv
module tb_ps2_scan_receiver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kclk = 1'b1;
    logic       kdat = 1'b1;
    logic       rd = 1'b0;
    logic [7:0] code;
    logic       rdy;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    localparam int HALF = 20;

    always #2.5 clk = ~clk;

    ps2_scan_receiver #(.SYNC_STAGES(2), .FILT_LEN(4)) dut (
        .clk(clk), .rst_n(rst_n), .ps2_clk_in(kclk), .ps2_dat_in(kdat),
        .rd_strobe(rd), .scan_code(code), .code_ready(rdy));

    task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] mk(logic [7:0] b, bit bs, bit bp, bit bt);
        logic par;
        par = ~^b ^ bp;
        return {~bt, par, b, bs};
    endfunction

    // Drive one bit: data set while clock high, then a low half period.
    task automatic ps2_bit(logic v);
        @(negedge clk) kdat = v;
        repeat (HALF/2) @(negedge clk);
        kclk = 1'b0;
        repeat (HALF) @(negedge clk);
        kclk = 1'b1;
        repeat (HALF/2) @(negedge clk);
    endtask

    task automatic send(logic [10:0] f);
        for (int i = 0; i < 11; i++) ps2_bit(f[i]);
        kdat = 1'b1;
        repeat (30) @(negedge clk);
    endtask

    task automatic do_read();
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 ready after reset", {1'b0, 7'b0, rdy}, 9'h000);
        chk("R1 code after reset", {1'b0, code}, 9'h000);
        for (int i = 0; i < 5; i++) ps2_bit(i[0]);
        @(negedge clk) rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        send(mk(8'h5A, 0, 0, 0));
        chk("R1 frame after mid-frame reset", {rdy, code}, {1'b1, 8'h5A});
        do_read();
    endtask

    task automatic t_basic();
        send(mk(8'h1C, 0, 0, 0));
        chk("R2 good frame 1C", {rdy, code}, {1'b1, 8'h1C});
        repeat (50) @(negedge clk);
        chk("R10 ready sticky", {rdy, code}, {1'b1, 8'h1C});
        do_read();
        chk("R6 read clears ready keeps code", {rdy, code}, {1'b0, 8'h1C});
        send(mk(8'hA5, 0, 0, 0));
        chk("R2 good frame A5", {rdy, code}, {1'b1, 8'hA5});
        do_read();
    endtask

    task automatic t_bad();
        send(mk(8'h33, 0, 1, 0));
        chk("R3 bad parity ignored", {rdy, code}, {1'b0, 8'hA5});
        send(mk(8'h44, 1, 0, 0));
        chk("R4 bad start ignored", {rdy, code}, {1'b0, 8'hA5});
        send(mk(8'h55, 0, 0, 1));
        chk("R5 bad stop ignored", {rdy, code}, {1'b0, 8'hA5});
    endtask

    task automatic t_overwrite();
        send(mk(8'h12, 0, 0, 0));
        send(mk(8'h34, 0, 0, 0));
        chk("R7 overwrite while ready", {rdy, code}, {1'b1, 8'h34});
        do_read();
    endtask

    task automatic t_sequence();
        logic [7:0] seq [5] = '{8'h1C, 8'h1C, 8'hF0, 8'h1C, 8'hE0};
        for (int i = 0; i < 5; i++) begin
            send(mk(seq[i], 0, 0, 0));
            chk("R8 byte delivered separately", {rdy, code}, {1'b1, seq[i]});
            do_read();
            chk("R8 cleared between codes", {1'b0, 7'b0, rdy}, 9'h000);
        end
    endtask

    task automatic t_glitch();
        logic [10:0] f;
        f = mk(8'h6B, 0, 0, 0);
        for (int i = 0; i < 11; i++) begin
            if (i == 4) begin
                @(negedge clk) kdat = f[i];
                repeat (3) @(negedge clk);
                kclk = 1'b0;
                repeat (2) @(negedge clk);
                kclk = 1'b1;
                repeat (HALF/2 - 5) @(negedge clk);
                kclk = 1'b0;
                repeat (HALF) @(negedge clk);
                kclk = 1'b1;
                repeat (HALF/2) @(negedge clk);
            end else begin
                ps2_bit(f[i]);
            end
        end
        kdat = 1'b1;
        repeat (30) @(negedge clk);
        chk("R9 short glitch rejected", {rdy, code}, {1'b1, 8'h6B});
        do_read();
    endtask

    task automatic t_collide();
        logic [10:0] f;
        f = mk(8'h2D, 0, 0, 0);
        for (int i = 0; i < 10; i++) ps2_bit(f[i]);
        @(negedge clk) kdat = f[10];
        repeat (HALF/2) @(negedge clk);
        kclk = 1'b0;
        repeat (7) @(posedge clk);
        @(negedge clk) rd = 1'b1;
        @(negedge clk) rd = 1'b0;
        chk("R11 capture wins over read", {rdy, code}, {1'b1, 8'h2D});
        repeat (HALF) @(negedge clk);
        kclk = 1'b1;
        kdat = 1'b1;
        repeat (20) @(negedge clk);
        chk("R11 still ready after collision", {rdy, code}, {1'b1, 8'h2D});
        do_read();
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_bad();
        t_overwrite();
        t_sequence();
        t_glitch();
        t_collide();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule